// File: doc/BRIEF.md
# Three-Level DMA Address Sequencer

This block produces the paired read and write addresses for a single DMA channel. The channel works from an active parameter set. The set gives a source start address and a destination start address. It gives the number of word beats in one array, the number of arrays in one frame and the number of frames in one block. It also gives separate array and frame strides for each side. Either side can instead run in constant mode, which holds its address at the start value, as suits a FIFO-style port. One address pair leaves on a valid/ready request stream for every beat.

A trigger starts a sync unit. The trigger may come from a manual strobe, an external event or a chain input, and the sync-mode field selects whether one unit is an array, a frame or the whole block. A small local table holds linkable parameter sets, and software programs the channel by copying one table entry into the active set. When the block completes, the link field of the finished set names the table entry that is loaded next. This repeats ping-pong, circular or continuous transfers without software action. A null link instead parks the channel. Completion can pulse a chain output and an interrupt. A trigger that arrives while a unit is still pending or running sets a sticky missed-event error and also pulses the interrupt.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, `parked` is 1 and `busy`, `req_valid`, `err_missed`, `irq` and `chain_out` are all 0.
- R2: For beat `a` of array `b` of frame `c` (all counted from 0), an increment-mode side outputs `start + c*frame_stride + b*array_stride + a*WB` modulo 2^AW, where WB is 4. The beat index `a` varies fastest and the frame index `c` slowest. Each stride is an AW-bit two's-complement value.
- R3: A side with its constant flag set outputs its start address on every beat of the set.
- R4: Sync field 0 makes one trigger move one array, 1 moves one frame, and 2 or 3 moves the whole remaining block. After the unit, `busy` drops and no further beat is offered until the next trigger.
- R5: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_src` and `req_dst` hold their values. A beat completes only in a cycle with both signals at 1.
- R6: The manual, event and chain trigger inputs each start a unit. Triggers that arrive together in one cycle count as a single event.
- R7: A trigger that arrives while `busy` is 1 is not queued. It sets `err_missed` and pulses `irq` in the next cycle. `err_missed` stays set until `err_clr`.
- R8: When the final beat of a block completes and the link field has its MSB clear, the table entry named by the low link bits becomes the active set and the channel waits idle for a trigger. In the cycle after that final beat, `chain_out` pulses if the set's chain-enable bit is set, and `irq` pulses if the set's interrupt-enable bit is set.
- R9: When a block completes and the link MSB is set (null link), the channel parks. While parked it ignores every trigger, with no beat and no error, until `pgm_go` loads a table entry.
- R10: `busy` is 1 from the cycle after an accepted trigger until the unit's last beat completes. `req_valid` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Write enable for the link table |
| tbl_idx | input | 2 | Table entry to write |
| tbl_wdata | input | PSET_W | Parameter set to write, packed in the package's set layout |
| pgm_go | input | 1 | Copy table entry `pgm_idx` into the active set; accepted only while `busy` is 0 |
| pgm_idx | input | 2 | Table entry to load |
| trig_manual | input | 1 | Manual start strobe |
| trig_evt | input | 1 | External event strobe |
| trig_chain | input | 1 | Chain trigger from another channel |
| err_clr | input | 1 | Clears `err_missed` |
| req_valid | output | 1 | An address pair is offered |
| req_ready | input | 1 | The consumer accepts the offered pair |
| req_src | output | AW | Read address of the beat |
| req_dst | output | AW | Write address of the beat |
| busy | output | 1 | A unit is pending or running |
| parked | output | 1 | Channel is halted after a null link or after reset |
| chain_out | output | 1 | One-cycle chain pulse on block completion |
| irq | output | 1 | One-cycle pulse on completion or on a missed event |
| err_missed | output | 1 | Sticky missed-event flag |

## Verification
The assertions check four properties on every cycle: the request stream holds steady under back-pressure, no request appears while the channel is idle or parked, the missed-event flag stays set until cleared and its setting is marked by an interrupt, and each chain pulse follows a completed beat. Only the bench scenarios can show that the three-level address arithmetic is correct for each sync granularity and constant-mode mix. The same holds for the split of a block into trigger-sized units, for link reload alternating between two table entries, and for a parked channel staying silent until it is reprogrammed.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  parameter int AW     = 16;
  parameter int CW     = 4;
  parameter int TDEPTH = 4;
  parameter int WB     = 4;
  localparam int IW    = $clog2(TDEPTH);
  localparam int LW    = IW + 1;

  typedef enum logic [1:0] {
    SYNC_ARRAY = 2'd0,
    SYNC_FRAME = 2'd1,
    SYNC_BLOCK = 2'd2,
    SYNC_ALL   = 2'd3
  } sync_e;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [CW-1:0] acnt;
    logic [CW-1:0] bcnt;
    logic [CW-1:0] ccnt;
    logic [AW-1:0] src_bstr;
    logic [AW-1:0] dst_bstr;
    logic [AW-1:0] src_cstr;
    logic [AW-1:0] dst_cstr;
    sync_e         sync;
    logic          src_const;
    logic          dst_const;
    logic [LW-1:0] link;
    logic          chain_en;
    logic          int_en;
  } pset_t;

  localparam int PSET_W = $bits(pset_t);
endpackage

// File: rtl/dma3d_ptable.sv
module dma3d_ptable
  import dma3d_pkg::*;
#(
  parameter int DEPTH = TDEPTH,
  localparam int XW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [XW-1:0] widx,
  input  pset_t         wdata,
  input  logic [XW-1:0] ridx,
  output pset_t         rdata
);
  pset_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                      mem[i] <= '0;
      else if (we && widx == XW'(i))   mem[i] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen #(
  parameter int AW = 16,
  parameter int WB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          hold_const,
  input  logic [AW-1:0] bstr,
  input  logic [AW-1:0] cstr,
  input  logic          step,
  input  logic          wrap_a,
  input  logic          wrap_b,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] cur_q, arr_q, frm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      arr_q <= '0;
      frm_q <= '0;
    end else if (load) begin
      cur_q <= base;
      arr_q <= base;
      frm_q <= base;
    end else if (step && !hold_const) begin
      if (!wrap_a) begin
        cur_q <= cur_q + AW'(WB);
      end else if (!wrap_b) begin
        arr_q <= arr_q + bstr;
        cur_q <= arr_q + bstr;
      end else begin
        frm_q <= frm_q + cstr;
        arr_q <= frm_q + cstr;
        cur_q <= frm_q + cstr;
      end
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/dma3d_ctrl.sv
module dma3d_ctrl
  import dma3d_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_go,
  input  logic [IW-1:0] pgm_idx,
  input  logic          trig_any,
  input  logic          err_clr,
  input  logic          req_ready,
  input  pset_t         tdata,
  output logic [IW-1:0] ridx,
  output pset_t         act,
  output logic          load,
  output logic          beat,
  output logic          wrap_a,
  output logic          wrap_b,
  output logic          req_valid,
  output logic          busy,
  output logic          parked,
  output logic          chain_out,
  output logic          irq,
  output logic          err_missed
);
  typedef enum logic [1:0] {S_PARK, S_IDLE, S_PEND, S_RUN} st_e;
  st_e st_q;
  logic [CW-1:0] a_rem, b_rem, c_rem;
  logic wrap_c, unit_end, link_null, pgm_ok, miss;

  assign link_null = act.link[LW-1];
  assign busy      = (st_q == S_PEND) || (st_q == S_RUN);
  assign parked    = (st_q == S_PARK);
  assign req_valid = (st_q == S_RUN);
  assign beat      = req_valid && req_ready;
  assign wrap_a    = (a_rem <= CW'(1));
  assign wrap_b    = wrap_a && (b_rem <= CW'(1));
  assign wrap_c    = wrap_b && (c_rem <= CW'(1));
  assign pgm_ok    = pgm_go && !busy;
  assign miss      = trig_any && busy;
  assign ridx      = (st_q == S_RUN) ? act.link[IW-1:0] : pgm_idx;
  assign load      = pgm_ok || (beat && wrap_c && !link_null);

  always_comb begin
    unit_end = 1'b0;
    if (beat) begin
      case (act.sync)
        SYNC_ARRAY: unit_end = wrap_a;
        SYNC_FRAME: unit_end = wrap_b;
        default:    unit_end = wrap_c;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= '0;
      a_rem <= '0;
      b_rem <= '0;
      c_rem <= '0;
    end else if (load) begin
      act   <= tdata;
      a_rem <= tdata.acnt;
      b_rem <= tdata.bcnt;
      c_rem <= tdata.ccnt;
    end else if (beat) begin
      a_rem <= wrap_a ? act.acnt : a_rem - CW'(1);
      if (wrap_a) b_rem <= wrap_b ? act.bcnt : b_rem - CW'(1);
      if (wrap_b) c_rem <= wrap_c ? act.ccnt : c_rem - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_PARK;
      chain_out  <= 1'b0;
      irq        <= 1'b0;
      err_missed <= 1'b0;
    end else begin
      chain_out  <= beat && wrap_c && act.chain_en;
      irq        <= (beat && wrap_c && act.int_en) || miss;
      err_missed <= miss || (err_missed && !err_clr);
      case (st_q)
        S_PARK: if (pgm_ok) st_q <= S_IDLE;
        S_IDLE: if (!pgm_ok && trig_any) st_q <= S_PEND;
        S_PEND: st_q <= S_RUN;
        default: if (unit_end) st_q <= (wrap_c && link_null) ? S_PARK : S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IW-1:0]     tbl_idx,
  input  logic [PSET_W-1:0] tbl_wdata,
  input  logic              pgm_go,
  input  logic [IW-1:0]     pgm_idx,
  input  logic              trig_manual,
  input  logic              trig_evt,
  input  logic              trig_chain,
  input  logic              err_clr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_src,
  output logic [ADDR_W-1:0] req_dst,
  output logic              busy,
  output logic              parked,
  output logic              chain_out,
  output logic              irq,
  output logic              err_missed
);
  pset_t         tdata, act;
  logic [IW-1:0] ridx;
  logic          load, beat, wrap_a, wrap_b;
  logic [AW-1:0] src_a, dst_a;

  dma3d_ptable #(.DEPTH(TDEPTH)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx),
    .wdata(pset_t'(tbl_wdata)), .ridx(ridx), .rdata(tdata)
  );

  dma3d_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pgm_go(pgm_go), .pgm_idx(pgm_idx),
    .trig_any(trig_manual | trig_evt | trig_chain), .err_clr(err_clr),
    .req_ready(req_ready), .tdata(tdata), .ridx(ridx), .act(act),
    .load(load), .beat(beat), .wrap_a(wrap_a), .wrap_b(wrap_b),
    .req_valid(req_valid), .busy(busy), .parked(parked),
    .chain_out(chain_out), .irq(irq), .err_missed(err_missed)
  );

  dma3d_addr_gen #(.AW(AW), .WB(WB)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .base(tdata.src),
    .hold_const(act.src_const), .bstr(act.src_bstr), .cstr(act.src_cstr),
    .step(beat), .wrap_a(wrap_a), .wrap_b(wrap_b), .addr(src_a)
  );

  dma3d_addr_gen #(.AW(AW), .WB(WB)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .base(tdata.dst),
    .hold_const(act.dst_const), .bstr(act.dst_bstr), .cstr(act.dst_cstr),
    .step(beat), .wrap_a(wrap_a), .wrap_b(wrap_b), .addr(dst_a)
  );

  assign req_src = ADDR_W'(src_a);
  assign req_dst = ADDR_W'(dst_a);
endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_src,
  input logic [ADDR_W-1:0] req_dst,
  input logic              busy,
  input logic              parked,
  input logic              chain_out,
  input logic              irq,
  input logic              err_missed,
  input logic              err_clr
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst)); // R5
  AST_PARK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> !req_valid && !busy); // R9
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy); // R10
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_missed && !err_clr |=> err_missed); // R7
  AST_MISS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_missed) |-> irq); // R7
  AST_CHAIN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out |-> $past(req_valid && req_ready)); // R8
endmodule

bind dma3d_seq dma3d_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_dst(req_dst), .busy(busy), .parked(parked),
  .chain_out(chain_out), .irq(irq), .err_missed(err_missed), .err_clr(err_clr)
);

// File: tb/sim_dma3d_seq.sv
module sim_dma3d_seq;
  import dma3d_pkg::*;

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, pgm_go = 0, trig_manual = 0, trig_evt = 0, trig_chain = 0;
  logic err_clr = 0, req_ready = 0;
  logic [IW-1:0] tbl_idx = '0, pgm_idx = '0;
  logic [PSET_W-1:0] tbl_wdata = '0;
  logic req_valid, busy, parked, chain_out, irq, err_missed;
  logic [AW-1:0] req_src, req_dst;

  int vec = 0, bad = 0, n_irq = 0, n_chain = 0;
  int ga = 0, gb = 0, gc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma3d_seq u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .pgm_go(pgm_go), .pgm_idx(pgm_idx),
    .trig_manual(trig_manual), .trig_evt(trig_evt), .trig_chain(trig_chain),
    .err_clr(err_clr), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .busy(busy), .parked(parked),
    .chain_out(chain_out), .irq(irq), .err_missed(err_missed)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base,
      input logic [AW-1:0] bs, input logic [AW-1:0] cs, input bit cnst,
      input int a, input int b, input int c);
    int s;
    if (cnst) return base;
    s = int'(base) + c * int'($signed(cs)) + b * int'($signed(bs)) + a * WB;
    return AW'(s);
  endfunction

  task automatic wr_tbl(input int idx, input pset_t p);
    @(negedge clk); tbl_we = 1; tbl_idx = IW'(idx); tbl_wdata = p;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic pgm(input int idx);
    @(negedge clk); pgm_go = 1; pgm_idx = IW'(idx);
    @(negedge clk); pgm_go = 0;
    ga = 0; gb = 0; gc = 0;
  endtask

  task automatic fire(input int kind);
    @(negedge clk);
    trig_manual = (kind == 0) || (kind == 3);
    trig_evt    = (kind == 1) || (kind == 3);
    trig_chain  = (kind == 2) || (kind == 3);
    @(negedge clk);
    trig_manual = 0; trig_evt = 0; trig_chain = 0;
  endtask

  task automatic serve(input pset_t p, input int pat, output int nb);
    bit hold = 0;
    logic [AW-1:0] hs = '0, hd = '0;
    bit rdy;
    nb = 0;
    for (int k = 0; k < 2000; k++) begin
      if (irq) n_irq++;
      if (chain_out) n_chain++;
      if (hold)
        chk(req_valid && req_src == hs && req_dst == hd, "R5", "held pair",
            int'(req_src), int'(hs));
      if (!busy) break;
      rdy = (pat == 0) ? 1'b1 : ((k + pat) % 3 != 0);
      req_ready = rdy;
      hold = req_valid && !rdy; hs = req_src; hd = req_dst;
      if (req_valid && rdy) begin
        chk(req_src == exp_addr(p.src, p.src_bstr, p.src_cstr, p.src_const, ga, gb, gc),
            p.src_const ? "R3" : "R2", "src addr", int'(req_src),
            int'(exp_addr(p.src, p.src_bstr, p.src_cstr, p.src_const, ga, gb, gc)));
        chk(req_dst == exp_addr(p.dst, p.dst_bstr, p.dst_cstr, p.dst_const, ga, gb, gc),
            p.dst_const ? "R3" : "R2", "dst addr", int'(req_dst),
            int'(exp_addr(p.dst, p.dst_bstr, p.dst_cstr, p.dst_const, ga, gb, gc)));
        nb++;
        ga++;
        if (ga == int'(p.acnt)) begin
          ga = 0; gb++;
          if (gb == int'(p.bcnt)) begin
            gb = 0; gc++;
            if (gc == int'(p.ccnt)) gc = 0;
          end
        end
      end
      @(negedge clk);
    end
    req_ready = 0;
  endtask

  function automatic pset_t mk(input int sm, input int ac, input int bc, input int cc,
                               input int fm, input logic [LW-1:0] lk);
    pset_t p;
    p = '0;
    p.src = 16'h1000; p.dst = 16'h8000;
    p.acnt = CW'(ac); p.bcnt = CW'(bc); p.ccnt = CW'(cc);
    p.src_bstr = 16'h0040; p.src_cstr = 16'h0200;
    p.dst_bstr = 16'hFFE0; p.dst_cstr = 16'h0100;
    p.sync = sync_e'(sm);
    p.src_const = fm[1]; p.dst_const = fm[0];
    p.link = lk; p.chain_en = fm[0]; p.int_en = 1'b1;
    return p;
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    pset_t p, q;
    int nb, units, usz;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(parked == 1, "R1", "parked", parked, 1);
    chk(busy == 0 && req_valid == 0, "R1", "busy/valid", {busy, req_valid}, 0);
    chk(err_missed == 0 && irq == 0 && chain_out == 0, "R1", "err/irq/chain",
        {err_missed, irq, chain_out}, 0);

    // R2 R3 R4 R6 R8 R9 sweep over shapes, sync modes and constant-mode mixes
    for (int sm = 0; sm < 3; sm++)
      for (int ai = 0; ai < 2; ai++)
        for (int bc = 1; bc <= 3; bc++)
          for (int cc = 1; cc <= 2; cc++)
            for (int fm = 0; fm < 4; fm++) begin
              p = mk(sm, ai ? 3 : 1, bc, cc, fm, {1'b1, {IW{1'b0}}});
              wr_tbl(0, p);
              pgm(0);
              n_irq = 0; n_chain = 0;
              units = (sm == 0) ? bc * cc : (sm == 1) ? cc : 1;
              usz = (sm == 0) ? (ai ? 3 : 1) : (sm == 1) ? (ai ? 3 : 1) * bc
                                                         : (ai ? 3 : 1) * bc * cc;
              for (int u = 0; u < units; u++) begin
                fire(u % 3);
                serve(p, (sm + fm + u) % 3, nb);
                chk(nb == usz, "R4", "beats per unit", nb, usz);
                if (u < units - 1)
                  chk(parked == 0 && req_valid == 0, "R4", "idle between units",
                      {parked, req_valid}, 0);
              end
              chk(parked == 1, "R9", "parked after null link", parked, 1);
              chk(n_irq == 1, "R8", "completion irq count", n_irq, 1);
              chk(n_chain == fm % 2, "R8", "chain pulse count", n_chain, fm % 2);
            end

    // R9 triggers while parked are ignored; pgm_go revives
    fire(0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && req_valid == 0 && err_missed == 0, "R9", "parked ignores trigger",
        {busy, req_valid, err_missed}, 0);
    pgm(0);
    chk(parked == 0, "R9", "pgm_go unparks", parked, 0);

    // R7 missed trigger: not queued, sticky flag, irq pulse
    p = mk(2, 3, 2, 1, 0, {1'b0, IW'(0)});
    wr_tbl(0, p);
    pgm(0);
    n_irq = 0;
    fire(0);
    trig_evt = 1;
    @(negedge clk);
    trig_evt = 0;
    chk(err_missed == 1, "R7", "missed flag", err_missed, 1);
    chk(irq == 1, "R7", "miss irq pulse", irq, 1);
    serve(p, 0, nb);
    chk(nb == 6, "R7", "beats of unit with miss", nb, 6);
    repeat (4) @(negedge clk);
    chk(busy == 0 && req_valid == 0, "R7", "miss not queued", {busy, req_valid}, 0);
    chk(err_missed == 1, "R7", "flag sticky", err_missed, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err_missed == 0, "R7", "err_clr clears", err_missed, 0);

    // R6 simultaneous sources merge into one event
    fire(3);
    serve(p, 1, nb);
    chk(nb == 6, "R6", "merged trigger beats", nb, 6);
    chk(err_missed == 0, "R6", "no miss on merge", err_missed, 0);

    // R8 ping-pong link between entries 1 and 2
    p = mk(2, 2, 2, 2, 1, {1'b0, IW'(2)}); p.src = 16'h2000;
    q = mk(2, 1, 3, 1, 1, {1'b0, IW'(1)}); q.dst = 16'h4400; q.src_const = 0;
    wr_tbl(1, p);
    wr_tbl(2, q);
    pgm(1);
    n_chain = 0;
    for (int r = 0; r < 4; r++) begin
      ga = 0; gb = 0; gc = 0;
      fire(r % 3);
      serve((r % 2) ? q : p, 2, nb);
      chk(nb == ((r % 2) ? 3 : 8), "R8", "linked set beats", nb, (r % 2) ? 3 : 8);
      chk(parked == 0, "R8", "link keeps channel live", parked, 0);
    end
    chk(n_chain == 4, "R8", "chain pulses over ping-pong", n_chain, 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule